// File: doc/BRIEF.md
# Iterative Booth Multiplier with Early Termination

This block multiplies two 32-bit integers and returns the 64-bit product. The operands are read as two's complement or as unsigned numbers, as a mode pin selects. Each clock cycle of work handles one slice of eight multiplier bits. Those bits are recoded into four radix-4 Booth digits. Each digit picks zero, plus or minus one times the multiplicand, or plus or minus two times the multiplicand. The four picked multiples are reduced by one row of 4-2 compressors. A second row of 4-2 compressors merges that result into a carry-save accumulator. A full operation needs four iterations. The block stops sooner when every multiplier bit not yet consumed matches the fill bit. The fill bit is the sign bit in signed mode and zero in unsigned mode. The bits checked include the bit just below the next slice. A final carry-propagate add turns the redundant pair into the product.

Operands arrive on a valid/ready stream and the product leaves on another. The block handles one operation at a time. `in_ready` is high only while the block is idle. A transfer happens on a rising edge where `in_valid` and `in_ready` are both high. After that edge `in_ready` stays low until the product has been taken. The product is offered with `out_valid` and is held unchanged while `out_ready` is low. It is consumed on the edge where both are high. `in_signed` is a plain pin that is sampled together with the operands.

Top module: `booth_iter_mul`

## Requirements
- R1: While reset is active, and after it is released, `in_ready` is 1 and `out_valid` is 0.
- R2: With `in_signed`=1, `out_prod` equals the 64-bit two's-complement product of `in_a` and `in_b`, both read as signed 32-bit values.
- R3: With `in_signed`=0, `out_prod` equals the 64-bit product of `in_a` and `in_b`, both read as unsigned values.
- R4: Corner operands give the exact product in both modes. These are 0, 1, all ones (−1 when signed) and 0x80000000 (the most negative value when signed), in any pairing.
- R5: `out_valid` rises n clock edges after the accepting edge. Here n is the smallest value in 1..3 for which bits 31 down to 8n−1 of `in_b` all equal the fill bit. If no such value exists, n is 4. The fill bit is `in_b[31]` when signed and 0 when unsigned.
- R6: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_prod` stays unchanged.
- R7: `in_ready` drops on the edge that accepts operands and stays low until the product is taken. It is 1 again in the cycle after the edge where `out_valid` and `out_ready` are both 1.
- R8: Any `in_valid`, `in_a`, `in_b` or `in_signed` activity while the block is busy has no effect on the product being computed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are valid |
| in_ready | output | 1 | Block is idle and accepts operands |
| in_signed | input | 1 | 1: two's complement operands, 0: unsigned operands |
| in_a | input | 32 | Multiplicand |
| in_b | input | 32 | Multiplier |
| out_valid | output | 1 | Product is valid |
| out_ready | input | 1 | Consumer takes the product |
| out_prod | output | 64 | Product |

## Verification
The product is due n edges after the accepting edge, with n between 1 and 4 as R5 defines it from the multiplier value. After driving an operation, the bench counts falling edges until `out_valid` appears. It compares that count with n, which a bench function computes from `in_b` and the mode. The product and the readiness flags are sampled on falling edges, half a cycle after the register updates they depend on. The product is compared in the same cycle `out_valid` is first seen, again on every cycle of back-pressure, and the cycle after the release confirms that `in_ready` has returned.

// File: rtl/bmul_pkg.sv
package bmul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DONE
  } bmul_state_e;

  // One radix-4 Booth digit as a select set.
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } booth_sel_t;

  // Group bits are {upper, middle, lower}; the lower bit belongs to the
  // group below. Digit value = -2*upper + middle + lower.
  function automatic booth_sel_t booth_decode(input logic [2:0] grp);
    booth_sel_t s;
    s = '0;
    case (grp)
      3'b001, 3'b010: s.one = 1'b1;
      3'b011:         s.two = 1'b1;
      3'b100:         begin s.two = 1'b1; s.neg = 1'b1; end
      3'b101, 3'b110: begin s.one = 1'b1; s.neg = 1'b1; end
      default:        s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/bmul_booth_pp.sv
// One Booth digit: selects the multiple of the extended multiplicand,
// inverts it for negative digits, and places it at its bit weight.
// The +1 that completes the negation is returned separately on inj.
module bmul_booth_pp #(
  parameter int W     = 64,
  parameter int STEP  = 8,
  parameter int OFF   = 0,
  parameter int CNT_W = 3
) (
  input  logic [2:0]       grp,
  input  logic [W-1:0]     mcand,
  input  logic [CNT_W-1:0] iter,
  output logic [W-1:0]     pp,
  output logic [W-1:0]     inj
);
  import bmul_pkg::*;

  localparam int SH_W = $clog2(W);

  booth_sel_t      sel;
  logic [W-1:0]    mag;
  logic [W-1:0]    raw;
  logic [SH_W-1:0] sh;

  always_comb begin
    sel = booth_decode(grp);
    if (sel.one)      mag = mcand;
    else if (sel.two) mag = mcand << 1;
    else              mag = '0;
    raw = sel.neg ? ~mag : mag;
    sh  = SH_W'(iter) * SH_W'(STEP) + SH_W'(OFF);
    pp  = raw << sh;
    inj = W'(sel.neg) << sh;
  end

endmodule

// File: rtl/bmul_csa42_row.sv
// Row of 4-2 compressors. The lateral carry out of a column depends only
// on a, b and c, so the row has no rippling path.
module bmul_csa42_row #(
  parameter int W = 64
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  output logic [W-1:0] sum,
  output logic [W-1:0] carry
);
  logic [W-1:0] lat;
  logic [W-2:0] cy;

  assign lat[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_col
    if (i < W - 1) begin : g_full
      logic t;
      assign t        = a[i] ^ b[i] ^ c[i];
      assign lat[i+1] = (a[i] & b[i]) | (a[i] & c[i]) | (b[i] & c[i]);
      assign sum[i]   = t ^ d[i] ^ lat[i];
      assign cy[i]    = (t & d[i]) | (t & lat[i]) | (d[i] & lat[i]);
    end else begin : g_top
      assign sum[i] = a[i] ^ b[i] ^ c[i] ^ d[i] ^ lat[i];
    end
  end

  assign carry = {cy, 1'b0};

endmodule

// File: rtl/booth_iter_mul.sv
module booth_iter_mul #(
  parameter int OP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_signed,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*OP_W-1:0] out_prod
);
  import bmul_pkg::*;

  localparam int NUM_PP   = 4;
  localparam int PROD_W   = 2 * OP_W;
  localparam int STEP     = 2 * NUM_PP;
  localparam int ITER_MAX = OP_W / STEP;
  localparam int CNT_W    = $clog2(ITER_MAX + 1);
  localparam int MR_W     = OP_W + 1;

  bmul_state_e       st;
  logic [CNT_W-1:0]  it_cnt;
  logic [PROD_W-1:0] mcand_q;
  logic [MR_W-1:0]   mr_q;
  logic              fill_q;
  logic [PROD_W-1:0] acc_s_q, acc_c_q, fix_q;

  logic [PROD_W-1:0] pp  [NUM_PP];
  logic [PROD_W-1:0] inj [NUM_PP];
  logic [PROD_W-1:0] pp_top;
  logic [PROD_W-1:0] s1, c1, s2, c2;
  logic [MR_W-1:0]   mr_nx;
  logic              last_it;

  // Booth digit selection, one instance per digit of the slice
  for (genvar k = 0; k < NUM_PP; k++) begin : g_digit
    bmul_booth_pp #(
      .W(PROD_W), .STEP(STEP), .OFF(2 * k), .CNT_W(CNT_W)
    ) u_pp (
      .grp  (mr_q[2*k+2 : 2*k]),
      .mcand(mcand_q),
      .iter (it_cnt),
      .pp   (pp[k]),
      .inj  (inj[k])
    );
  end

  // Lower digits' +1 bits sit in the empty low zone of the top multiple
  assign pp_top = pp[NUM_PP-1] | inj[0] | inj[1] | inj[2];

  bmul_csa42_row #(.W(PROD_W)) u_row_pp (
    .a(pp[0]), .b(pp[1]), .c(pp[2]), .d(pp_top),
    .sum(s1), .carry(c1)
  );

  bmul_csa42_row #(.W(PROD_W)) u_row_acc (
    .a(s1), .b(c1), .c(acc_s_q), .d(acc_c_q),
    .sum(s2), .carry(c2)
  );

  // Multiplier shift row and early termination test
  assign mr_nx   = {{STEP{fill_q}}, mr_q[MR_W-1:STEP]};
  assign last_it = (it_cnt == CNT_W'(ITER_MAX - 1)) ||
                   (mr_nx == {MR_W{fill_q}});

  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);
  assign out_prod  = acc_s_q + acc_c_q + fix_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      it_cnt  <= '0;
      mcand_q <= '0;
      mr_q    <= '0;
      fill_q  <= 1'b0;
      acc_s_q <= '0;
      acc_c_q <= '0;
      fix_q   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (in_valid) begin
          st      <= ST_RUN;
          it_cnt  <= '0;
          mcand_q <= in_signed ? {{OP_W{in_a[OP_W-1]}}, in_a}
                               : {{OP_W{1'b0}}, in_a};
          mr_q    <= {in_b, 1'b0};
          fill_q  <= in_signed & in_b[OP_W-1];
          acc_s_q <= '0;
          acc_c_q <= '0;
          // Unsigned top digit: +multiplicand at weight 2^OP_W
          fix_q   <= (!in_signed && in_b[OP_W-1]) ? {in_a, {OP_W{1'b0}}}
                                                  : '0;
        end
        ST_RUN: begin
          acc_s_q <= s2;
          acc_c_q <= c2;
          mr_q    <= mr_nx;
          fix_q   <= fix_q | inj[NUM_PP-1];
          it_cnt  <= it_cnt + 1'b1;
          if (last_it) st <= ST_DONE;
        end
        ST_DONE: if (out_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R6: product held under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R7: acceptance closes the input side
  p_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R5: completion only when the termination rule is met
  p_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ((mr_q == {MR_W{fill_q}}) ||
                          (it_cnt == CNT_W'(ITER_MAX))));

  // R5: never more than the full iteration count
  p_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (it_cnt < CNT_W'(ITER_MAX)));

  // R8: captured multiplicand untouched while busy
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(mcand_q));

endmodule

// File: tb/booth_iter_mul_bench.sv
module booth_iter_mul_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_signed = 1'b0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [63:0] out_prod;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  booth_iter_mul u_booth_iter_mul (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_signed(in_signed),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_prod(out_prod)
  );

  function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, bit s);
    logic [63:0] ea, eb;
    ea = s ? {{32{a[31]}}, a} : {32'b0, a};
    eb = s ? {{32{b[31]}}, b} : {32'b0, b};
    return ea * eb;
  endfunction

  function automatic int ref_iters(logic [31:0] b, bit s);
    logic fill;
    fill = s & b[31];
    for (int n = 1; n < 4; n++) begin
      bit ok = 1'b1;
      for (int i = 8 * n - 1; i < 32; i++) if (b[i] != fill) ok = 1'b0;
      if (ok) return n;
    end
    return 4;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_one(logic [31:0] a, logic [31:0] b, bit s,
                         int hold, bit junk, string req);
    logic [63:0] exp;
    int lat;
    exp = ref_prod(a, b, s);
    @(negedge clk);
    chk(in_ready == 1'b1, "R7 idle", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_a = a; in_b = b; in_signed = s;
    @(negedge clk);
    chk(in_ready == 1'b0, "R7 busy", 64'(in_ready), 64'd0);
    if (junk) begin
      // R8: new operands offered while busy
      in_a = ~a; in_b = b ^ 32'h5A5A_A5A5; in_signed = ~s;
    end else begin
      in_valid = 1'b0;
    end
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == ref_iters(b, s), "R5 latency", 64'(lat), 64'(ref_iters(b, s)));
    chk(out_prod == exp, req, out_prod, exp);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && out_prod == exp, "R6 hold", out_prod, exp);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R7 release",
        {in_ready, out_valid}, 64'b10);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [4];
    logic [31:0] ra, rb;
    void'($urandom(32'd20240611));
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
    corner[2] = 32'hFFFF_FFFF; corner[3] = 32'h8000_0000;

    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 in reset",
        {in_ready, out_valid}, 64'b10);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R1 after reset",
        {in_ready, out_valid}, 64'b10);

    // R4: corner operand pairings in both modes
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++) begin
        run_one(corner[i], corner[j], 1'b1, 0, 1'b0, "R4 R2 corner signed");
        run_one(corner[i], corner[j], 1'b0, 0, 1'b0, "R4 R3 corner unsigned");
      end

    // R5: one operand per iteration count, both signs
    run_one(32'h1357_9BDF, 32'h0000_0005, 1'b1, 0, 1'b0, "R5 R2 n1");
    run_one(32'h1357_9BDF, 32'h0000_1234, 1'b1, 0, 1'b0, "R5 R2 n2");
    run_one(32'h1357_9BDF, 32'h003B_CDEF, 1'b1, 0, 1'b0, "R5 R2 n3");
    run_one(32'h1357_9BDF, 32'h00AB_CDEF, 1'b1, 0, 1'b0, "R5 R2 n4");
    run_one(32'hDEAD_BEEF, 32'hFFFF_FF9C, 1'b1, 0, 1'b0, "R5 R2 neg n1");
    run_one(32'hDEAD_BEEF, 32'hFFFF_FF7F, 1'b1, 0, 1'b0, "R5 R2 neg n2");
    run_one(32'hDEAD_BEEF, 32'h0000_0080, 1'b0, 0, 1'b0, "R5 R3 bit7 n2");
    run_one(32'hDEAD_BEEF, 32'hFFFF_FF9C, 1'b0, 0, 1'b0, "R5 R3 unsigned n4");

    // R6 and R8: back-pressure and busy-time input activity
    run_one(32'h8765_4321, 32'hF00D_CAFE, 1'b1, 5, 1'b1, "R8 R2 junk signed");
    run_one(32'h8765_4321, 32'h0000_00C3, 1'b0, 3, 1'b1, "R8 R3 junk unsigned");

    // Constrained random, widths spread to reach every iteration count
    for (int t = 0; t < 300; t++) begin
      bit s;
      ra = $urandom();
      rb = $urandom();
      s  = $urandom_range(0, 1);
      case ($urandom_range(0, 3))
        0: rb = rb >> $urandom_range(1, 31);
        1: rb = ~(rb >> $urandom_range(1, 31));
        default: ;
      endcase
      run_one(ra, rb, s, $urandom_range(0, 2), bit'($urandom_range(0, 1)),
              s ? "R2 random signed" : "R3 random unsigned");
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule